// File: doc/BRIEF.md
# DAC Output Code Update and Clear Controller

This block decides when the code that drives a digital-to-analog converter changes. A serial front end delivers committed writes. Each write carries a select and a data word, and the block stores it either as the next output code or as a programmable clear code. A write can also be a control command that starts a software clear or a software reset. The block watches the frame-select level, an active-low load pin and an active-low clear pin. From these it decides whether the pending code is moved into the active output register, and when.

The update mode follows the load pin during a frame. If the load pin is held low for the whole frame, the output takes the new code as soon as the frame ends. If the load pin is high at any point in the frame, the new code waits for a later falling edge of the load pin while frame select is high. A clear input held low for long enough forces the output to the clear code. While the clear input is low, nothing else can reach the output.

All inputs are taken as already synchronous to `clk`. The asynchronous active-low reset is released synchronously inside the block.

Top module: `dac_upd_ctrl`

## Requirements
- R1: After the hardware reset is released, the output code is zero and the stored clear code is zero.
- R2: Synchronous mode. Suppose `load_n` is sampled low on every clock edge while `frame_sel` is low, and an input-code write (`reg_wr_sel` = 0) is taken during that frame. Then `dac_code` takes the written code at the clock edge where `frame_sel` is first sampled high.
- R3: A frame that ends with `load_n` held low but with no input-code write inside it leaves `dac_code` unchanged.
- R4: Asynchronous mode. If `load_n` is sampled high at any edge of the frame, the end of the frame leaves `dac_code` unchanged. A later edge with `frame_sel` high, where `load_n` is sampled low after having been sampled high, loads the input code into `dac_code`.
- R5: If `clear_n` is sampled low on CLR_MIN consecutive edges, `dac_code` becomes the clear code at the CLR_MIN-th edge. A shorter low pulse leaves `dac_code` unchanged.
- R6: While `clear_n` is sampled low, no load of either mode changes `dac_code`.
- R7: After `clear_n` returns high with `load_n` high, `dac_code` keeps the clear code until the next load.
- R8: A write with `reg_wr_sel` = 1 stores the clear code and does not change `dac_code` by itself.
- R9: A control write (`reg_wr_sel` = 2) with data bit 0 set makes `dac_code` equal to the clear code one edge after the write edge. The command bit then clears itself and acts only once.
- R10: A control write with data bit 1 set returns the input code, the clear code and `dac_code` to zero one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr_stb | input | 1 | Committed-write strobe from the serial port, one cycle per write |
| reg_wr_sel | input | 2 | Write target: 0 input code, 1 clear code, 2 control |
| reg_wr_data | input | CODE_W | Write data; for control writes bit 0 is soft clear and bit 1 is soft reset |
| frame_sel | input | 1 | Frame-select level; low while a frame is being shifted |
| load_n | input | 1 | Active-low load pin |
| clear_n | input | 1 | Active-low clear pin |
| dac_code | output | CODE_W | Active output code |

## Verification
The bench builds the block with a 20-bit code and a clear qualification length of three cycles instead of the default two. With that length, a one-cycle or two-cycle clear pulse is a distinct case that must be rejected. The 20-bit width lets the randomized frames reach codes with the top bit set. Random sync and async frames are mixed with clear-code rewrites, and a directed case places a load attempt inside a held clear.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
  typedef enum logic [1:0] {
    SEL_INPUT = 2'd0,
    SEL_CLEAR = 2'd1,
    SEL_CTRL  = 2'd2
  } wr_sel_e;

  localparam int unsigned CTRL_SOFT_CLR_BIT = 0;
  localparam int unsigned CTRL_SOFT_RST_BIT = 1;
endpackage

// File: rtl/dac_upd_edges.sv
module dac_upd_edges (
  input  logic clk,
  input  logic rst_ni,
  input  logic soft_rst,
  input  logic frame_sel,
  input  logic load_n,
  input  logic in_wr,
  output logic sync_ld,
  output logic async_ld
);
  logic fs_q, fs_d;
  logic ld_q, ld_d;
  logic low_all_q, low_all_d;
  logic wrote_q, wrote_d;
  logic fs_rise, fs_fall;

  assign fs_rise = frame_sel & ~fs_q;
  assign fs_fall = ~frame_sel & fs_q;

  always_comb begin
    fs_d      = frame_sel;
    ld_d      = load_n;
    low_all_d = low_all_q;
    wrote_d   = wrote_q;
    if (fs_fall) begin
      low_all_d = ~load_n;
    end else if (!frame_sel) begin
      low_all_d = low_all_q & ~load_n;
    end
    if (fs_rise) begin
      wrote_d = 1'b0;
    end else if (in_wr && !frame_sel) begin
      wrote_d = 1'b1;
    end
    if (soft_rst) begin
      fs_d      = 1'b1;
      ld_d      = 1'b1;
      low_all_d = 1'b0;
      wrote_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q      <= 1'b1;
      ld_q      <= 1'b1;
      low_all_q <= 1'b0;
      wrote_q   <= 1'b0;
    end else begin
      fs_q      <= fs_d;
      ld_q      <= ld_d;
      low_all_q <= low_all_d;
      wrote_q   <= wrote_d;
    end
  end

  assign sync_ld  = fs_rise & low_all_q & wrote_q;
  assign async_ld = frame_sel & ld_q & ~load_n;
endmodule

// File: rtl/dac_upd_clrq.sv
module dac_upd_clrq #(
  parameter int unsigned CLR_MIN = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic soft_rst,
  input  logic clear_n,
  output logic clr_hold,
  output logic clr_force
);
  localparam int unsigned CNT_W   = $clog2(CLR_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLR_MIN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;

  assign cnt_en = soft_rst | clear_n | (cnt_q != CNT_TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (soft_rst || clear_n) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign clr_hold  = ~clear_n;
  assign clr_force = ~clear_n & (cnt_q == CNT_TOP);
endmodule

// File: rtl/dac_upd_regs.sv
module dac_upd_regs
  import dac_upd_pkg::*;
#(
  parameter int unsigned CODE_W = 20
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_stb,
  input  logic [1:0]        wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              sync_ld,
  input  logic              async_ld,
  input  logic              clr_hold,
  input  logic              clr_force,
  output logic              in_wr,
  output logic              soft_clr_q,
  output logic              soft_rst_q,
  output logic [CODE_W-1:0] in_code_q,
  output logic [CODE_W-1:0] clr_code_q,
  output logic [CODE_W-1:0] dac_q
);
  logic [CODE_W-1:0] in_code_d, clr_code_d, dac_d;
  logic soft_clr_d, soft_rst_d;
  logic cc_wr, ctrl_wr;

  assign in_wr   = wr_stb & (wr_sel == SEL_INPUT);
  assign cc_wr   = wr_stb & (wr_sel == SEL_CLEAR);
  assign ctrl_wr = wr_stb & (wr_sel == SEL_CTRL);

  always_comb begin
    in_code_d  = in_code_q;
    clr_code_d = clr_code_q;
    dac_d      = dac_q;
    soft_clr_d = ctrl_wr & wr_data[CTRL_SOFT_CLR_BIT];
    soft_rst_d = ctrl_wr & wr_data[CTRL_SOFT_RST_BIT];
    if (in_wr) in_code_d = wr_data;
    if (cc_wr) clr_code_d = wr_data;
    if (clr_force || soft_clr_q) begin
      dac_d = clr_code_q;
    end else if (clr_hold) begin
      dac_d = dac_q;
    end else if (async_ld || sync_ld) begin
      dac_d = in_code_q;
    end
    if (soft_rst_q) begin
      in_code_d  = '0;
      clr_code_d = '0;
      dac_d      = '0;
      soft_clr_d = 1'b0;
      soft_rst_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      in_code_q  <= '0;
      clr_code_q <= '0;
      dac_q      <= '0;
      soft_clr_q <= 1'b0;
      soft_rst_q <= 1'b0;
    end else begin
      in_code_q  <= in_code_d;
      clr_code_q <= clr_code_d;
      dac_q      <= dac_d;
      soft_clr_q <= soft_clr_d;
      soft_rst_q <= soft_rst_d;
    end
  end
endmodule

// File: rtl/dac_upd_ctrl.sv
module dac_upd_ctrl #(
  parameter int unsigned CODE_W  = 20,
  parameter int unsigned CLR_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_stb,
  input  logic [1:0]        reg_wr_sel,
  input  logic [CODE_W-1:0] reg_wr_data,
  input  logic              frame_sel,
  input  logic              load_n,
  input  logic              clear_n,
  output logic [CODE_W-1:0] dac_code
);
  logic [1:0] rst_sync_q;
  logic rst_sync_n;
  logic sync_ld, async_ld, clr_hold, clr_force, in_wr;
  logic soft_clr_w, soft_rst_w;
  logic [CODE_W-1:0] in_code_w, clr_code_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  dac_upd_edges u_edges (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .soft_rst (soft_rst_w),
    .frame_sel(frame_sel),
    .load_n   (load_n),
    .in_wr    (in_wr),
    .sync_ld  (sync_ld),
    .async_ld (async_ld)
  );

  dac_upd_clrq #(.CLR_MIN(CLR_MIN)) u_clrq (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .soft_rst (soft_rst_w),
    .clear_n  (clear_n),
    .clr_hold (clr_hold),
    .clr_force(clr_force)
  );

  dac_upd_regs #(.CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .wr_stb    (reg_wr_stb),
    .wr_sel    (reg_wr_sel),
    .wr_data   (reg_wr_data),
    .sync_ld   (sync_ld),
    .async_ld  (async_ld),
    .clr_hold  (clr_hold),
    .clr_force (clr_force),
    .in_wr     (in_wr),
    .soft_clr_q(soft_clr_w),
    .soft_rst_q(soft_rst_w),
    .in_code_q (in_code_w),
    .clr_code_q(clr_code_w),
    .dac_q     (dac_code)
  );
endmodule

// File: rtl/dac_upd_ctrl_chk.sv
module dac_upd_ctrl_chk #(
  parameter int unsigned CODE_W  = 20,
  parameter int unsigned CLR_MIN = 2
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              frame_sel,
  input logic              load_n,
  input logic              clear_n,
  input logic [CODE_W-1:0] dac_code,
  input logic [CODE_W-1:0] in_code,
  input logic [CODE_W-1:0] clr_code,
  input logic              soft_clr,
  input logic              soft_rst
);
  int unsigned low_cnt;
  logic ld_prev, fs_prev;
  logic forced, quiet;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= 0;
      ld_prev <= 1'b1;
      fs_prev <= 1'b1;
    end else if (soft_rst) begin
      low_cnt <= 0;
      ld_prev <= 1'b1;
      fs_prev <= 1'b1;
    end else begin
      ld_prev <= load_n;
      fs_prev <= frame_sel;
      if (clear_n) low_cnt <= 0;
      else if (low_cnt < CLR_MIN - 1) low_cnt <= low_cnt + 1;
    end
  end

  assign forced = !clear_n && (low_cnt >= CLR_MIN - 1);
  assign quiet  = !soft_clr && !soft_rst;

  // R5
  hw_clear_force_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (forced && quiet) |=> (dac_code == $past(clr_code)));

  // R6
  clear_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clear_n && !forced && quiet) |=> $stable(dac_code));

  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (soft_clr && !soft_rst) |=> (dac_code == $past(clr_code)));

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_rst |=> (dac_code == '0 && clr_code == '0 && in_code == '0));

  // R4
  async_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (frame_sel && ld_prev && !load_n && clear_n && quiet) |=> (dac_code == $past(in_code)));

  // R7
  hold_without_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (clear_n && quiet && !(frame_sel && !fs_prev) && !(frame_sel && ld_prev && !load_n))
      |=> $stable(dac_code));
endmodule

bind dac_upd_ctrl dac_upd_ctrl_chk #(.CODE_W(CODE_W), .CLR_MIN(CLR_MIN)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_sync_n),
  .frame_sel(frame_sel),
  .load_n   (load_n),
  .clear_n  (clear_n),
  .dac_code (dac_code),
  .in_code  (in_code_w),
  .clr_code (clr_code_w),
  .soft_clr (soft_clr_w),
  .soft_rst (soft_rst_w)
);

// File: tb/dac_upd_ctrl_bench.sv
module dac_upd_ctrl_bench;
  localparam int CW = 20;
  localparam int CLRM = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_stb;
  logic [1:0] wr_sel;
  logic [CW-1:0] wr_data;
  logic frame_sel, load_n, clear_n;
  logic [CW-1:0] dac_code;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] exp_dac, exp_cc;

  always #5 clk = ~clk;

  dac_upd_ctrl #(.CODE_W(CW), .CLR_MIN(CLRM)) u_dac_upd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_stb(wr_stb), .reg_wr_sel(wr_sel),
    .reg_wr_data(wr_data), .frame_sel(frame_sel), .load_n(load_n),
    .clear_n(clear_n), .dac_code(dac_code)
  );

  function automatic logic [CW-1:0] rand_code();
    return CW'($urandom);
  endfunction

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dac_code=%h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [CW-1:0] d);
    wr_stb = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0; wr_data = '0;
  endtask

  task automatic sync_frame(input logic [CW-1:0] c, input bit do_wr, input string req);
    frame_sel = 1'b0; load_n = 1'b0;
    @(negedge clk);
    if (do_wr) wr(2'd0, c); else @(negedge clk);
    frame_sel = 1'b1;
    @(negedge clk);
    if (do_wr && clear_n) exp_dac = c;
    chk(req, dac_code, exp_dac);
    load_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic async_frame(input logic [CW-1:0] c);
    frame_sel = 1'b0; load_n = 1'b1;
    @(negedge clk);
    wr(2'd0, c);
    frame_sel = 1'b1;
    @(negedge clk);
    chk("R4 no update at frame end", dac_code, exp_dac);
    load_n = 1'b0;
    @(negedge clk);
    exp_dac = c;
    chk("R4 update on load fall", dac_code, exp_dac);
    load_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, checks=%0d expected completion", checks);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_stb = 1'b0; wr_sel = '0; wr_data = '0;
    frame_sel = 1'b1; load_n = 1'b1; clear_n = 1'b1;
    exp_dac = '0; exp_cc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset output", dac_code, '0);

    // R1: clear code is zero after reset, seen through a soft clear
    sync_frame(20'hABCDE, 1'b1, "R2 sync load");
    wr(2'd2, 20'h1);
    @(negedge clk);
    exp_dac = '0;
    chk("R1 reset clear code", dac_code, exp_dac);

    sync_frame(20'h80001, 1'b1, "R2 sync load top bit");
    sync_frame(20'h12345, 1'b0, "R3 no write no update");
    async_frame(20'h5A5A5);

    // R8: clear-code write alone leaves output
    exp_cc = 20'hC1EA2;
    wr(2'd1, exp_cc);
    @(negedge clk);
    chk("R8 clear code write", dac_code, exp_dac);

    // R5: short pulse rejected
    clear_n = 1'b0;
    repeat (CLRM - 1) @(negedge clk);
    clear_n = 1'b1;
    @(negedge clk);
    chk("R5 short clear ignored", dac_code, exp_dac);

    // R5, R6, R7
    clear_n = 1'b0;
    repeat (CLRM - 1) @(negedge clk);
    chk("R5 before qualify", dac_code, exp_dac);
    @(negedge clk);
    exp_dac = exp_cc;
    chk("R5 clear applied", dac_code, exp_dac);
    frame_sel = 1'b0;
    @(negedge clk);
    wr(2'd0, 20'h0F0F0);
    frame_sel = 1'b1;
    @(negedge clk);
    load_n = 1'b0;
    @(negedge clk);
    chk("R6 load blocked in clear", dac_code, exp_dac);
    load_n = 1'b1;
    @(negedge clk);
    clear_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 clear value kept", dac_code, exp_dac);
    load_n = 1'b0;
    @(negedge clk);
    exp_dac = 20'h0F0F0;
    chk("R7 next load after clear", dac_code, exp_dac);
    load_n = 1'b1;
    @(negedge clk);

    // R9: soft clear, acts once
    wr(2'd2, 20'h1);
    @(negedge clk);
    exp_dac = exp_cc;
    chk("R9 soft clear", dac_code, exp_dac);
    async_frame(20'h33333);
    chk("R9 self clear", dac_code, 20'h33333);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int pick;
      pick = int'($urandom % 4);
      if (pick == 0) sync_frame(rand_code(), 1'b1, "R2 random sync");
      else if (pick == 1) async_frame(rand_code());
      else if (pick == 2) begin
        exp_cc = rand_code();
        wr(2'd1, exp_cc);
        @(negedge clk);
        chk("R8 random clear code", dac_code, exp_dac);
      end else begin
        wr(2'd2, 20'h1);
        @(negedge clk);
        exp_dac = exp_cc;
        chk("R9 random soft clear", dac_code, exp_dac);
      end
    end

    // R10: soft reset
    wr(2'd2, 20'h2);
    @(negedge clk);
    exp_dac = '0; exp_cc = '0;
    chk("R10 soft reset output", dac_code, '0);
    frame_sel = 1'b1; load_n = 1'b0;
    @(negedge clk);
    chk("R10 input code zero", dac_code, '0);
    load_n = 1'b1;
    @(negedge clk);
    wr(2'd2, 20'h1);
    @(negedge clk);
    chk("R10 clear code zero", dac_code, '0);

    // R1: hardware reset mid-run
    sync_frame(20'h7777A, 1'b1, "R2 pre reset");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_dac = '0;
    chk("R1 hw reset again", dac_code, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule